// File: doc/BRIEF.md
# Glide-Tap Feedback Echo Delay

This block is the echo stage of a fixed-point audio effect. On every sample strobe it takes one signed input sample and adds a scaled copy of a feedback sample to it. The feedback sample arrives on an input port from a later processing stage. The sum is saturated and written into a circular sample ring. In the same sample the block then reads one older sample back out of the ring.

The read distance, or tap, comes from an unsigned delay-time control. That control has only a few hundred coarse steps, so it is not used directly. It sets a target tap, and a very slow one-pole smoother with fractional state pulls the actual tap toward that target once per sample. A change of delay time therefore glides smoothly instead of jumping. The delayed sample goes on to the next stage, and the current integer tap is also made available.

The ring depth, sample width, control widths, smoother precision and smoothing coefficient are all parameters. The default coefficient is 2097/2^24, which is close to 0.000125 per sample. A production instance sets the depth to 26600 samples.

Top module: `glide_echo_delay`

## Requirements
- R1: While reset is held and until the first strobe, `echo_o` and `tap_o` read 0 and `echo_vld_o` is low.
- R2: `echo_vld_o` is high in exactly the cycle after each strobe. Without a strobe, `echo_vld_o` is low and `echo_o` and `tap_o` keep their values.
- R3: The target tap is floor(DEPTH × `time_i` / 2^CTRL_W). With `time_i` held, the tap settles at that value, whose maximum is DEPTH−1.
- R4: The smoother state has FRAC_W fractional bits and changes once per strobe. The update adds the term (target·2^FRAC_W − state) × SMOOTH_COEF + 2^(COEF_FRAC−1), arithmetically shifted right by COEF_FRAC. The tap in use is the state rounded to the nearest integer, with halves rounding up.
- R5: On the first strobe after reset the smoother state is forced to 0, whatever `time_i` is, so that sample uses tap 0.
- R6: The written value is `smp_i` + floor(`fb_i` × `fb_amt_i` / 2^FB_CTRL_W), saturated to the signed DATA_W range. For 24 bits that range is −8388608 to 8388607.
- R7: The write happens before the read. With tap 0, `echo_o` equals the value written in that same sample.
- R8: With tap t, `echo_o` equals the value written t strobes earlier. Ring addresses wrap modulo DEPTH, including at t = DEPTH−1.
- R9: `tap_o` never exceeds DEPTH−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb_i | input | 1 | One sample is processed in each cycle this is high |
| smp_i | input | DATA_W | Signed input sample |
| fb_i | input | DATA_W | Signed feedback sample from the later stage |
| time_i | input | CTRL_W | Unsigned delay-time fraction, value/2^CTRL_W |
| fb_amt_i | input | FB_CTRL_W | Unsigned feedback gain, value/2^FB_CTRL_W |
| echo_o | output | DATA_W | Delayed sample, registered |
| tap_o | output | idx_bits(DEPTH) | Integer tap used in the last sample |
| echo_vld_o | output | 1 | High in the cycle after a strobe |

## Verification
The main instance is built with DEPTH = 100, which is not a power of two. This lets the fold-around address path wrap many times in a few hundred samples, and lets the largest tap of 99 be reached. That instance uses a coefficient of one half, so a glide converges in about twenty samples and its rounding corner cases, including the final unit step, can be compared against an exact model. A second instance uses the default coefficient of 2097/2^24. It shows the first integer step of a realistic slow glide after about forty samples, and that the fractional state is long enough for such a small coefficient to make progress.

// File: rtl/glide_echo_pkg.sv
package glide_echo_pkg;
   localparam int unsigned DEF_DATA_W    = 24;
   localparam int unsigned DEF_DEPTH     = 1330;
   localparam int unsigned DEF_CTRL_W    = 9;
   localparam int unsigned DEF_FB_CTRL_W = 9;
   localparam int unsigned DEF_FRAC_W    = 16;
   localparam int unsigned DEF_COEF_FRAC = 24;
   localparam int unsigned DEF_COEF      = 2097;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/glide_fb_mixer.sv
module glide_fb_mixer #(
   parameter int unsigned DATA_W    = 24,
   parameter int unsigned FB_CTRL_W = 9
) (
   input  logic signed [DATA_W-1:0]    smp_i,
   input  logic signed [DATA_W-1:0]    fb_i,
   input  logic        [FB_CTRL_W-1:0] amt_i,
   output logic signed [DATA_W-1:0]    scaled_o,
   output logic signed [DATA_W-1:0]    wr_o
);
   localparam int unsigned PROD_W = DATA_W + FB_CTRL_W + 1;
   localparam int unsigned SUM_W  = DATA_W + 1;
   localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [PROD_W-1:0] fb_x;
   logic signed [PROD_W-1:0] amt_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [SUM_W-1:0]  sum;

   always_comb begin
      fb_x     = PROD_W'(fb_i);
      amt_x    = $signed(PROD_W'(amt_i));
      prod     = fb_x * amt_x;
      scaled_o = DATA_W'(prod >>> FB_CTRL_W);
      sum      = SUM_W'(smp_i) + SUM_W'(scaled_o);
      if (sum[SUM_W-1] != sum[SUM_W-2]) begin
         wr_o = sum[SUM_W-1] ? NEG_MIN : POS_MAX;
      end else begin
         wr_o = sum[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/glide_tap_smoother.sv
module glide_tap_smoother
   import glide_echo_pkg::*;
#(
   parameter int unsigned DEPTH     = DEF_DEPTH,
   parameter int unsigned CTRL_W    = DEF_CTRL_W,
   parameter int unsigned FRAC_W    = DEF_FRAC_W,
   parameter int unsigned COEF_FRAC = DEF_COEF_FRAC,
   parameter int unsigned COEF      = DEF_COEF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        step_i,
   input  logic [CTRL_W-1:0]           ctrl_i,
   output logic [idx_bits(DEPTH)-1:0]  tap_o,
   output logic [idx_bits(DEPTH)-1:0]  tap_q_o
);
   localparam int unsigned IDX_W  = idx_bits(DEPTH);
   localparam int unsigned DEP_W  = $clog2(DEPTH + 1);
   localparam int unsigned TGT_W  = DEP_W + CTRL_W;
   localparam int unsigned ST_W   = IDX_W + FRAC_W;
   localparam int unsigned DIFF_W = ST_W + 1;
   localparam int unsigned CF_W   = COEF_FRAC + 1;
   localparam int unsigned PROD_W = DIFF_W + CF_W;
   localparam logic [DEP_W-1:0]  DEPTH_V = DEP_W'(DEPTH);
   localparam logic [IDX_W-1:0]  TAP_MAX = IDX_W'(DEPTH - 1);
   localparam logic [CF_W-1:0]   COEF_V  = CF_W'(COEF);
   localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (COEF_FRAC - 1);
   localparam logic [ST_W:0]     TAP_RND = (ST_W + 1)'(1) << (FRAC_W - 1);

   logic [TGT_W-1:0]         tgt_full;
   logic [IDX_W-1:0]         tgt;
   logic [ST_W-1:0]          tgt_fx;
   logic [ST_W-1:0]          st_q;
   logic [ST_W-1:0]          st_upd;
   logic [ST_W-1:0]          st_new;
   logic signed [DIFF_W-1:0] diff;
   logic signed [PROD_W-1:0] diff_x;
   logic signed [PROD_W-1:0] coef_x;
   logic signed [PROD_W-1:0] prod_r;
   logic [ST_W:0]            tap_round;
   logic [IDX_W:0]           tap_wide;
   logic                     started_q;
   logic [IDX_W-1:0]         tap_q;

   always_comb begin
      tgt_full  = TGT_W'(DEPTH_V) * TGT_W'(ctrl_i);
      tgt       = IDX_W'(tgt_full >> CTRL_W);
      tgt_fx    = {tgt, {FRAC_W{1'b0}}};
      diff      = $signed({1'b0, tgt_fx}) - $signed({1'b0, st_q});
      diff_x    = PROD_W'(diff);
      coef_x    = $signed(PROD_W'(COEF_V));
      prod_r    = diff_x * coef_x + HALF_LSB;
      st_upd    = st_q + ST_W'(prod_r >>> COEF_FRAC);
      st_new    = started_q ? st_upd : '0;
      tap_round = (ST_W + 1)'(st_new) + TAP_RND;
      tap_wide  = (IDX_W + 1)'(tap_round >> FRAC_W);
      tap_o     = (tap_wide > (IDX_W + 1)'(TAP_MAX)) ? TAP_MAX : tap_wide[IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= '0;
         started_q <= 1'b0;
         tap_q     <= '0;
      end else if (step_i) begin
         st_q      <= st_new;
         started_q <= 1'b1;
         tap_q     <= tap_o;
      end
   end

   assign tap_q_o = tap_q;

   // R9
   tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_q <= TAP_MAX);

   // R5
   first_tap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !started_q) |=> (tap_q == '0 && st_q == '0));

   // R4
   glide_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && started_q && (st_q < tgt_fx)) |=>
         (st_q >= $past(st_q) && st_q <= $past(tgt_fx)));

   // R4
   glide_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && started_q && (st_q > tgt_fx)) |=>
         (st_q <= $past(st_q) && st_q >= $past(tgt_fx)));
endmodule

// File: rtl/glide_delay_ring.sv
module glide_delay_ring
   import glide_echo_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned DEPTH  = DEF_DEPTH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [idx_bits(DEPTH)-1:0] tap_i,
   output logic [DATA_W-1:0]          rdata_o
);
   localparam int unsigned IDX_W   = idx_bits(DEPTH);
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(DEPTH - 1);

   logic [DATA_W-1:0] ring_mem [DEPTH];
   logic [IDX_W-1:0]  wp_q;
   logic [IDX_W-1:0]  rd_addr;

   generate
      if (is_pow2(DEPTH)) begin : g_mask_wrap
         assign rd_addr = wp_q - tap_i;
      end else begin : g_fold_wrap
         localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);
         assign rd_addr = (wp_q >= tap_i) ? (wp_q - tap_i)
                                          : (wp_q + DEPTH_I - tap_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i) begin
         ring_mem[wp_q] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rdata_o <= '0;
      end else if (we_i) begin
         rdata_o <= (tap_i == '0) ? wdata_i : ring_mem[rd_addr];
         wp_q    <= (wp_q == LAST_I) ? '0 : wp_q + 1'b1;
      end
   end

   // R8
   wp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_q <= LAST_I);

   // R8
   wp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(wp_q));

   // R8
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> rd_addr <= LAST_I);
endmodule

// File: rtl/glide_echo_delay.sv
module glide_echo_delay
   import glide_echo_pkg::*;
#(
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned DEPTH       = DEF_DEPTH,
   parameter int unsigned CTRL_W      = DEF_CTRL_W,
   parameter int unsigned FB_CTRL_W   = DEF_FB_CTRL_W,
   parameter int unsigned FRAC_W      = DEF_FRAC_W,
   parameter int unsigned COEF_FRAC   = DEF_COEF_FRAC,
   parameter int unsigned SMOOTH_COEF = DEF_COEF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        smp_stb_i,
   input  logic signed [DATA_W-1:0]    smp_i,
   input  logic signed [DATA_W-1:0]    fb_i,
   input  logic [CTRL_W-1:0]           time_i,
   input  logic [FB_CTRL_W-1:0]        fb_amt_i,
   output logic signed [DATA_W-1:0]    echo_o,
   output logic [idx_bits(DEPTH)-1:0]  tap_o,
   output logic                        echo_vld_o
);
   localparam int unsigned IDX_W = idx_bits(DEPTH);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("FRAC_W must be at least 2");
      end
      if (COEF_FRAC < 2 || COEF_FRAC > 30) begin : g_bad_coef_frac
         $error("COEF_FRAC must lie in 2..30");
      end
      if (SMOOTH_COEF < 1 || SMOOTH_COEF > (1 << (COEF_FRAC - 1))) begin : g_bad_coef
         $error("SMOOTH_COEF must lie in 1..2^(COEF_FRAC-1)");
      end
   endgenerate

   logic signed [DATA_W-1:0] fb_scaled;
   logic signed [DATA_W-1:0] wr_val;
   logic [IDX_W-1:0]         tap_now;
   logic [DATA_W-1:0]        ring_out;
   logic                     vld_q;

   glide_fb_mixer #(
      .DATA_W    (DATA_W),
      .FB_CTRL_W (FB_CTRL_W)
   ) u_mix (
      .smp_i    (smp_i),
      .fb_i     (fb_i),
      .amt_i    (fb_amt_i),
      .scaled_o (fb_scaled),
      .wr_o     (wr_val)
   );

   glide_tap_smoother #(
      .DEPTH     (DEPTH),
      .CTRL_W    (CTRL_W),
      .FRAC_W    (FRAC_W),
      .COEF_FRAC (COEF_FRAC),
      .COEF      (SMOOTH_COEF)
   ) u_smooth (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (smp_stb_i),
      .ctrl_i  (time_i),
      .tap_o   (tap_now),
      .tap_q_o (tap_o)
   );

   glide_delay_ring #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (smp_stb_i),
      .wdata_i (wr_val),
      .tap_i   (tap_now),
      .rdata_o (ring_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= smp_stb_i;
      end
   end

   assign echo_vld_o = vld_q;
   assign echo_o     = $signed(ring_out);

   // R2
   vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb_i |=> echo_vld_o);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb_i |=> (!echo_vld_o && $stable(echo_o) && $stable(tap_o)));

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb_i && (smp_i[DATA_W-1] == fb_scaled[DATA_W-1])) |->
         (wr_val[DATA_W-1] == smp_i[DATA_W-1]));

   // R7
   tap0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb_i && tap_now == '0) |=> (echo_o == $past(wr_val)));
endmodule

// File: tb/glide_echo_delay_tb.sv
module glide_echo_delay_tb;
   localparam int unsigned DATA_W    = 24;
   localparam int unsigned DEPTH     = 100;
   localparam int unsigned CTRL_W    = 9;
   localparam int unsigned FB_CTRL_W = 8;
   localparam int unsigned FRAC_W    = 16;
   localparam int unsigned COEF_FRAC = 24;
   localparam int unsigned FAST_COEF = 1 << 23;
   localparam int unsigned SLOW_COEF = 2097;
   localparam int unsigned IDX_W     = 7;
   localparam int         HIST_N    = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic signed [DATA_W-1:0] smp = '0;
   logic signed [DATA_W-1:0] fb = '0;
   logic [CTRL_W-1:0] tctl = '0;
   logic [FB_CTRL_W-1:0] famt = '0;
   logic signed [DATA_W-1:0] echo, echo_s;
   logic [IDX_W-1:0] tap, tap_s;
   logic vld, vld_s;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   longint s_fast = 0, s_slow = 0;
   bit started = 1'b0;
   longint hist [HIST_N];
   int wcount = 0;

   always #4 clk = ~clk;

   glide_echo_delay #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .CTRL_W(CTRL_W), .FB_CTRL_W(FB_CTRL_W),
      .FRAC_W(FRAC_W), .COEF_FRAC(COEF_FRAC), .SMOOTH_COEF(FAST_COEF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_stb_i(smp_stb), .smp_i(smp), .fb_i(fb),
      .time_i(tctl), .fb_amt_i(famt), .echo_o(echo), .tap_o(tap), .echo_vld_o(vld)
   );

   glide_echo_delay #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .CTRL_W(CTRL_W), .FB_CTRL_W(FB_CTRL_W),
      .FRAC_W(FRAC_W), .COEF_FRAC(COEF_FRAC), .SMOOTH_COEF(SLOW_COEF)
   ) u_slow (
      .clk(clk), .rst_n(rst_n), .smp_stb_i(smp_stb), .smp_i(smp), .fb_i(fb),
      .time_i(tctl), .fb_amt_i(famt), .echo_o(echo_s), .tap_o(tap_s), .echo_vld_o(vld_s)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint next_state(input longint s, input longint tgt,
                                         input longint coef, input bit run);
      longint d, p;
      if (!run) return 0;
      d = (tgt << FRAC_W) - s;
      p = d * coef + (longint'(1) << (COEF_FRAC - 1));
      return s + (p >>> COEF_FRAC);
   endfunction

   function automatic longint tap_of(input longint s);
      longint t;
      t = (s + (longint'(1) << (FRAC_W - 1))) >>> FRAC_W;
      if (t > DEPTH - 1) t = DEPTH - 1;
      return t;
   endfunction

   function automatic longint write_of(input longint x, input longint f, input longint a);
      longint v;
      v = x + ((f * a) >>> FB_CTRL_W);
      if (v > 8388607) v = 8388607;
      if (v < -8388608) v = -8388608;
      return v;
   endfunction

   // One sample through the block; checks tap (R4), echo (R7/R8) and valid (R2).
   task automatic do_sample(input longint x, input longint f);
      longint tgt, wv, tf, ts, exp_echo;
      @(negedge clk);
      smp = DATA_W'(x);
      fb = DATA_W'(f);
      smp_stb = 1'b1;
      tgt = (longint'(DEPTH) * longint'(tctl)) >>> CTRL_W;
      s_fast = next_state(s_fast, tgt, FAST_COEF, started);
      s_slow = next_state(s_slow, tgt, SLOW_COEF, started);
      started = 1'b1;
      tf = tap_of(s_fast);
      ts = tap_of(s_slow);
      wv = write_of(x, f, longint'(famt));
      hist[wcount] = wv;
      @(negedge clk);
      smp_stb = 1'b0;
      chk("R2 valid after strobe", longint'(vld), 1);
      chk("R4 fast tap", longint'(tap), tf);
      chk("R4 slow tap", longint'(tap_s), ts);
      if (tf == 0) begin
         chk("R7 tap0 echo", longint'(echo), wv);
      end else if (wcount - tf >= 0) begin
         exp_echo = hist[wcount - int'(tf)];
         chk("R8 delayed echo", longint'(echo), exp_echo);
      end
      wcount++;
   endtask

   task automatic t_reset;
      chk("R1 echo at reset", longint'(echo), 0);
      chk("R1 tap at reset", longint'(tap), 0);
      chk("R1 valid at reset", longint'(vld), 0);
   endtask

   task automatic t_first_sample;
      logic signed [DATA_W-1:0] held;
      tctl = 9'd511;
      famt = '0;
      do_sample(1000, 0);
      chk("R5 first tap zero", longint'(tap), 0);
      chk("R5 slow first tap zero", longint'(tap_s), 0);
      chk("R7 first echo", longint'(echo), 1000);
      held = echo;
      @(negedge clk);
      chk("R2 valid low when idle", longint'(vld), 0);
      chk("R2 echo held when idle", longint'(echo), longint'(held));
   endtask

   task automatic t_glide(input int ctl, input int n, input int exp_tap);
      tctl = CTRL_W'(ctl);
      for (int i = 0; i < n; i++) do_sample(longint'(i * 37 - 500), 0);
      chk("R3 settled tap", longint'(tap), exp_tap);
   endtask

   task automatic t_delay(input int n);
      for (int i = 0; i < n; i++) do_sample(longint'(i * 1013 + 7), 0);
   endtask

   task automatic t_wrap_max;
      t_glide(511, 40, 99);
      t_delay(230);
      chk("R9 max tap", longint'(tap), DEPTH - 1);
   endtask

   task automatic t_feedback;
      t_glide(0, 30, 0);
      famt = 8'd64;
      do_sample(1000, -4000);
      chk("R6 fb cancel", longint'(echo), 0);
      famt = 8'd128;
      do_sample(100, 4001);
      chk("R6 fb positive floor", longint'(echo), 2100);
      do_sample(0, -4001);
      chk("R6 fb negative floor", longint'(echo), -2001);
      famt = 8'd0;
   endtask

   task automatic t_saturate;
      famt = 8'd255;
      do_sample(8388000, 8388607);
      chk("R6 positive saturation", longint'(echo), 8388607);
      do_sample(-8388000, -8388608);
      chk("R6 negative saturation", longint'(echo), -8388608);
      famt = 8'd0;
   endtask

   task automatic t_slow_glide;
      tctl = 9'd511;
      for (int i = 0; i < 60; i++) do_sample(longint'(i), 0);
      chk("R4 slow glide progressed", longint'(tap_s >= 1), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_first_sample;
      t_glide(256, 30, 50);
      t_delay(60);
      t_glide(128, 30, 25);
      t_delay(40);
      t_wrap_max;
      t_feedback;
      t_saturate;
      t_glide(0, 30, 0);
      t_slow_glide;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule